// File: doc/BRIEF.md
# Buffered Serial Transmitter with Room and Line-End Flags

This block is the sending half of a FIFO-buffered asynchronous serial port. The bus side pushes bytes into a 64-entry queue. The block moves each byte from the head of the queue into a shift register and sends it on `txd` as a frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts one period of the externally supplied `baud_tick`. The fill level of the queue is available on `fill_cnt`.

Two status flags go back to software. `tx_end` shows that the line is idle and nothing is queued. `room_flag` shows that draining has brought the queue down to a programmable threshold, so software can write a batch of new bytes. The threshold comes from a 2-bit selector held in a configuration register. `room_flag` is protected against careless clearing. Software must first read it as 1 and then write 0 to it, and the clear takes effect only while the queue holds more bytes than the threshold.

A synchronous manual reset (`mrst`) returns the block to its power-on state. The full reset is `rst_n`, which is synchronous and active low.

Top module: `txq_serial`

## Requirements
- R1: After reset: `tx_end`=1, `room_flag`=1, `fill_cnt`=0, `txd`=1, and threshold code 00 is selected.
- R2: An accepted `wr_en` adds 1 to `fill_cnt`, and a dequeue into the shift register subtracts 1. When both happen in one cycle, the count stays the same. A write made when `fill_cnt`=64 is discarded and changes nothing.
- R3: A frame starts on a `baud_tick` cycle, and `txd` can change only after a `baud_tick` cycle. The bit order is 0, d[0]..d[7], 1. The line idles at 1. A new frame follows the stop bit with no gap when data is waiting.
- R4: `tx_end` goes to 0 on the clock after an accepted write.
- R5: `tx_end` goes to 1 on the clock after the stop bit ends, if the queue is empty and no write is accepted in that cycle. It stays 1 until a write is accepted.
- R6: `room_flag` goes to 1 when a dequeue leaves the resulting count at or below the threshold. The threshold depends on `cfg_trig`: code 00 gives 8, 01 gives 16, 10 gives 32, and 11 gives 48.
- R7: `room_flag` goes to 0 only when all of these hold: a status write (`stat_wr`=1, `stat_wdat`=0) follows a status read made while the flag was 1, and the resulting count exceeds the threshold. A write of 1 has no effect.
- R8: A write of 0 with no preceding read of 1 is ignored. Every status write cancels the armed read.
- R9: `mrst`=1 empties the queue, idles the line, and restores the R1 state on the next clock.
- R10: Bytes are sent in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mrst | input | 1 | Synchronous manual reset, active high |
| baud_tick | input | 1 | One-cycle pulse for each bit period |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| stat_rd | input | 1 | Status read strobe (arms the clear when `room_flag`=1) |
| stat_wr | input | 1 | Status write strobe |
| stat_wdat | input | 1 | Value written to `room_flag` |
| cfg_wr | input | 1 | Load `cfg_trig` into the threshold register |
| cfg_trig | input | 2 | Threshold selector code |
| txd | output | 1 | Serial line |
| tx_end | output | 1 | Line idle and queue empty |
| room_flag | output | 1 | Queue at or below threshold after draining |
| fill_cnt | output | 7 | Bytes currently queued |

## Verification
Two things can happen in the same cycle. A bus write can enqueue a byte on the same edge that a baud tick dequeues one. A status clear-write can also land on the cycle where that dequeue takes the count across the threshold. Both must be judged on the resulting count. The bench sets up these collisions in two ways. It keeps writing while ticks run, and it mixes random phases with different write densities, status traffic and threshold changes. A cycle-level model built from the requirements predicts every output, and each output is compared with the model on every cycle.

// File: rtl/txq_pkg.sv
// Package: shared sizes and threshold decode for the serial transmit queue.
// Assumes the queue depth is a power of two and a multiple of 8.
package txq_pkg;
    localparam int DEPTH   = 64;
    localparam int DW      = 8;
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int FRAME_W = DW + 2;

    // Maps the 2-bit selector to a threshold count (R6).
    function automatic logic [CW-1:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   trig_level = CW'(DEPTH / 8);
            2'b01:   trig_level = CW'(DEPTH / 4);
            2'b10:   trig_level = CW'(DEPTH / 2);
            default: trig_level = CW'((DEPTH * 3) / 4);
        endcase
    endfunction
endpackage

// File: rtl/txq_fifo.sv
// Module: byte queue with an occupancy count.
// Assumes the consumer never pops when the queue is empty. A push made
// while the queue is full is dropped.
module txq_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          push_ok
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign push_ok = push && (count != CW'(DEPTH));
    assign head    = mem[rptr];

    // Storage write; holds no reset state.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Pointer and count update (R2).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop)     rptr <= rptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop);
        end
    end
endmodule

// File: rtl/txq_shifter.sv
// Module: frame serializer. It loads a byte only on a baud tick, so every
// bit, including the start bit, lasts exactly one tick period.
// Assumes have_data means that head is valid.
module txq_shifter #(
    parameter int DW = 8,
    localparam int FW = DW + 2,
    localparam int IW = $clog2(FW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          have_data,
    input  logic [DW-1:0] data,
    output logic          pop,
    output logic          frame_done,
    output logic          txd
);
    logic          busy;
    logic [FW-1:0] sh;
    logic [IW-1:0] idx;
    logic          last;

    assign last       = busy && (idx == IW'(FW - 1));
    assign frame_done = tick && last;
    assign pop        = tick && (!busy || last) && have_data;
    assign txd        = busy ? sh[0] : 1'b1;

    // Load a frame, then shift out one bit per tick (R3).
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            sh   <= '1;
            idx  <= '0;
        end else if (pop) begin
            busy <= 1'b1;
            sh   <= {1'b1, data, 1'b0};
            idx  <= '0;
        end else if (tick && busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                sh  <= {1'b1, sh[FW-1:1]};
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txq_flags.sv
// Module: the line-end flag and the clear-protected room flag.
// Assumes pop and push_ok are the values the queue acts on this cycle.
module txq_flags #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] count,
    input  logic          push_ok,
    input  logic          pop,
    input  logic          frame_done,
    input  logic [CW-1:0] trig,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic          stat_wdat,
    output logic          tx_end,
    output logic          room
);
    logic [CW-1:0] cnt_next;
    logic          armed;
    logic          set_room, clr_room;

    assign cnt_next = count + CW'(push_ok) - CW'(pop);
    assign set_room = pop && (cnt_next <= trig);
    assign clr_room = stat_wr && !stat_wdat && armed && (cnt_next > trig);

    // Line-end flag: a write clears it; the last stop bit with nothing queued sets it (R4, R5).
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                      tx_end <= 1'b1;
        else if (push_ok)                       tx_end <= 1'b0;
        else if (frame_done && count == '0)     tx_end <= 1'b1;
    end

    // Room flag: set by draining, cleared only by the armed protocol (R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   room <= 1'b1;
        else if (set_room)   room <= 1'b1;
        else if (clr_room)   room <= 1'b0;
    end

    // Read-armed state: a read of 1 arms it, any status write cancels it (R8).
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          armed <= 1'b0;
        else if (stat_wr)           armed <= 1'b0;
        else if (stat_rd && room)   armed <= 1'b1;
    end
endmodule

// File: rtl/txq_serial.sv
// Module: top of the buffered serial transmitter. It holds the threshold
// register and connects the queue, serializer and flags.
// Assumes baud_tick is a one-cycle pulse; all resets are synchronous.
module txq_serial
    import txq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mrst,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic          stat_wdat,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_trig,
    output logic          txd,
    output logic          tx_end,
    output logic          room_flag,
    output logic [CW-1:0] fill_cnt
);
    logic [1:0]    trig_q;
    logic [DW-1:0] head;
    logic          push_ok, pop, frame_done;

    // Threshold selector register (R6, R1).
    always_ff @(posedge clk) begin
        if (!rst_n || mrst) trig_q <= 2'b00;
        else if (cfg_wr)    trig_q <= cfg_trig;
    end

    txq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(mrst),
        .push(wr_en), .push_data(wr_data), .pop(pop),
        .head(head), .count(fill_cnt), .push_ok(push_ok)
    );

    txq_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(mrst), .tick(baud_tick),
        .have_data(fill_cnt != '0), .data(head),
        .pop(pop), .frame_done(frame_done), .txd(txd)
    );

    txq_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(mrst),
        .count(fill_cnt), .push_ok(push_ok), .pop(pop),
        .frame_done(frame_done), .trig(trig_level(trig_q)),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdat(stat_wdat),
        .tx_end(tx_end), .room(room_flag)
    );
endmodule

// File: rtl/txq_serial_chk.sv
// Module: port-level properties for txq_serial, attached by bind.
module txq_serial_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mrst,
    input logic          baud_tick,
    input logic          wr_en,
    input logic          stat_wr,
    input logic          stat_wdat,
    input logic          txd,
    input logic          tx_end,
    input logic          room_flag,
    input logic [CW-1:0] fill_cnt
);
    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));
    // R2
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !baud_tick && !mrst) |=> $stable(fill_cnt));
    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !mrst) |=> $stable(txd));
    // R4
    end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_cnt != CW'(DEPTH) && !mrst) |=> !tx_end);
    // R5
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && !wr_en) |=> tx_end);
    // R7
    room_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (room_flag && !(stat_wr && !stat_wdat)) |=> room_flag);
    // R9
    mrst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (tx_end && room_flag && txd && fill_cnt == '0));
endmodule

bind txq_serial txq_serial_chk #(.DEPTH(txq_pkg::DEPTH), .CW(txq_pkg::CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .baud_tick(baud_tick),
    .wr_en(wr_en), .stat_wr(stat_wr), .stat_wdat(stat_wdat),
    .txd(txd), .tx_end(tx_end), .room_flag(room_flag), .fill_cnt(fill_cnt)
);

// File: tb/txq_serial_bench.sv
module txq_serial_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, mrst = 1'b0, baud_tick = 1'b0;
    logic       wr_en = 1'b0, stat_rd = 1'b0, stat_wr = 1'b0, stat_wdat = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_trig = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_end, room_flag;
    logic [6:0] fill_cnt;

    int checks = 0, errors = 0;
    bit tick_en = 1'b1;
    int div = 0;

    // Reference model state
    logic [7:0] q [64];
    int qh = 0, qt = 0, m_cnt = 0, m_idx = 0;
    bit m_busy = 0, m_tend = 1, m_room = 1, m_arm = 0;
    logic [9:0] m_sh = '1;
    logic [1:0] m_trig = 0;

    always #2.5 clk = ~clk;

    txq_serial u_txq_serial (.*);

    function automatic int trig_of(logic [1:0] c);
        case (c) 2'b00: return 8; 2'b01: return 16; 2'b10: return 32; default: return 48; endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        qh = 0; qt = 0; m_cnt = 0; m_idx = 0; m_busy = 0;
        m_tend = 1; m_room = 1; m_arm = 0; m_sh = '1; m_trig = 0;
    endtask

    // One clock: apply inputs, advance the model, compare at the next falling edge.
    task automatic cyc();
        bit acc, last, pop, n_room, n_arm, n_tend;
        int ncnt, tl;
        baud_tick = tick_en && (div == 3);
        div = (div + 1) % 4;
        if (!rst_n || mrst) model_reset();
        else begin
            acc  = wr_en && (m_cnt < 64);
            last = m_busy && (m_idx == 9);
            pop  = baud_tick && (!m_busy || last) && (m_cnt > 0);
            ncnt = m_cnt + int'(acc) - int'(pop);
            tl   = trig_of(m_trig);
            n_room = m_room;
            if (pop && ncnt <= tl) n_room = 1;
            else if (stat_wr && !stat_wdat && m_arm && ncnt > tl) n_room = 0;
            n_arm = stat_wr ? 0 : ((stat_rd && m_room) ? 1 : m_arm);
            n_tend = acc ? 0 : ((baud_tick && last && m_cnt == 0) ? 1 : m_tend);
            if (pop) begin
                m_sh = {1'b1, q[qh], 1'b0}; qh = (qh + 1) % 64; m_busy = 1; m_idx = 0;
            end else if (baud_tick && m_busy) begin
                if (last) m_busy = 0;
                else begin m_sh = {1'b1, m_sh[9:1]}; m_idx++; end
            end
            if (acc) begin q[qt] = wr_data; qt = (qt + 1) % 64; end
            if (cfg_wr) m_trig = cfg_trig;
            m_cnt = ncnt; m_room = n_room; m_arm = n_arm; m_tend = n_tend;
        end
        @(negedge clk);
        chk("R2 fill_cnt", fill_cnt, m_cnt);
        chk("R3 R10 txd", txd, m_busy ? m_sh[0] : 1'b1);
        chk("R4 R5 tx_end", tx_end, m_tend);
        chk("R6 R7 room_flag", room_flag, m_room);
        wr_en = 0; stat_rd = 0; stat_wr = 0; cfg_wr = 0; mrst = 0;
    endtask

    task automatic push(logic [7:0] d);
        wr_en = 1; wr_data = d; cyc();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1..R10 run incomplete) actual=hung expected=done");
        summary();
    end

    initial begin
        int wp;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        rst_n = 0; idle(3); rst_n = 1;
        // R1 reset state
        chk("R1 tx_end", tx_end, 1); chk("R1 room_flag", room_flag, 1);
        chk("R1 fill_cnt", fill_cnt, 0); chk("R1 txd", txd, 1);

        // R3 R10: three frames back to back
        push(8'hA5); push(8'h3C); push(8'hFF);
        idle(140);
        chk("R5 tx_end after drain", tx_end, 1);

        // R8: write 0 without a read is ignored
        tick_en = 0;
        for (int i = 0; i < 20; i++) push(8'(i * 7));
        stat_wr = 1; stat_wdat = 0; cyc();
        chk("R8 room kept without read", room_flag, 1);
        // R7: write of 1 after a read does nothing; read then 0 clears
        stat_rd = 1; cyc(); stat_wr = 1; stat_wdat = 1; cyc();
        chk("R7 write 1 no effect", room_flag, 1);
        stat_wr = 1; stat_wdat = 0; cyc();
        chk("R8 arm cancelled by write", room_flag, 1);
        stat_rd = 1; cyc(); stat_wr = 1; stat_wdat = 0; cyc();
        chk("R7 cleared above threshold", room_flag, 0);

        // R9 manual reset
        mrst = 1; cyc();
        chk("R9 fill", fill_cnt, 0); chk("R9 room", room_flag, 1); chk("R9 end", tx_end, 1);

        // R6 R7: threshold 48, clear refused at or below it
        cfg_wr = 1; cfg_trig = 2'b11; cyc();
        for (int i = 0; i < 20; i++) push(8'(i + 100));
        stat_rd = 1; cyc(); stat_wr = 1; stat_wdat = 0; cyc();
        chk("R7 refused at or below threshold", room_flag, 1);
        // R2: overfill, extra writes dropped
        for (int i = 0; i < 60; i++) push(8'(i ^ 8'h5A));
        chk("R2 full count", fill_cnt, 64);
        stat_rd = 1; cyc(); stat_wr = 1; stat_wdat = 0; cyc();
        chk("R7 clear when full", room_flag, 0);
        tick_en = 1;
        idle(800);
        chk("R6 set after drain to 48", room_flag, 1);
        // R2: writes colliding with dequeues
        for (int i = 0; i < 200; i++) push(8'($urandom));
        idle(2700);
        chk("R5 idle after drain", tx_end, 1);

        // Random phases with varying write density
        for (int ph = 0; ph < 30; ph++) begin
            wp = 1 + ($urandom % 8);
            for (int i = 0; i < 1500; i++) begin
                wr_en     = ($urandom % 16) < wp;
                wr_data   = 8'($urandom);
                stat_rd   = ($urandom % 6) == 0;
                stat_wr   = !stat_rd && (($urandom % 6) == 0);
                stat_wdat = ($urandom % 4) == 0;
                cfg_wr    = ($urandom % 300) == 0;
                cfg_trig  = 2'($urandom);
                mrst      = ($urandom % 3000) == 0;
                cyc();
            end
        end
        summary();
    end
endmodule